// File: doc/BRIEF.md
# CPU Wait-State Stretcher with Watchdog Release

This block holds a processor's bus cycle open while a floppy disk controller gets ready to move a byte in double-density mode. Software writes the drive control register with its wait-enable bit set. This raises an internal wait request, and the active-low `wait_n` output stalls the CPU. The stall ends when the disk controller raises its data request, when it raises its interrupt request at the end of a transfer, or when reset is applied.

A watchdog counter also runs while the stall lasts. If the controller never answers, the watchdog frees the CPU after a fixed number of clock cycles. This keeps a faulty controller from holding the CPU long enough to starve memory refresh. A sticky flag records that the watchdog fired, so software can tell a timeout apart from a normal handshake.

The block has no data path. All pins are plain control and status signals, so no valid/ready back-pressure applies.

Top module: `wait_stretch_ctl`

## Requirements
- R1: While `rst_n` is low, `wait_n` reads 1 and `wdog_timeout` reads 0. Asserting `rst_n` low during an active wait releases it at once, without waiting for a clock edge.
- R2: A write (`ctl_wr` high) with `ctl_wait_en` high (bit 6 of the drive control byte) while no wait is active drives `wait_n` low from the next rising clock edge.
- R3: A write with `ctl_wait_en` low never drives `wait_n` low.
- R4: If `fdc_drq` is high in a cycle in which the wait is active, `wait_n` returns to 1 at the next rising edge.
- R5: If `fdc_intrq` is high in a cycle in which the wait is active, `wait_n` returns to 1 at the next rising edge.
- R6: Without a handshake, `wait_n` stays low for exactly `WDOG_CYCLES` clock cycles and then returns to 1. It is never low for more than `WDOG_CYCLES` consecutive cycles.
- R7: `wdog_timeout` is set when the watchdog releases the wait. This means the terminal cycle is reached with both `fdc_drq` and `fdc_intrq` low. A handshake that arrives in the terminal cycle releases the wait without setting the flag. Once set, the flag stays at 1 until reset.
- R8: A second enabling write while a wait is already active is ignored. It neither extends the wait nor restarts the watchdog.
- R9: A wait requested while `fdc_drq` is already high is low for exactly one cycle and is released at the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, also a release condition |
| ctl_wr | input | 1 | One-cycle strobe for a write to the drive control register |
| ctl_wait_en | input | 1 | Wait-enable bit (bit 6) of the written byte |
| fdc_drq | input | 1 | Data request from the disk controller |
| fdc_intrq | input | 1 | Interrupt request from the disk controller |
| wait_n | output | 1 | Active-low CPU wait |
| wdog_timeout | output | 1 | Sticky flag: the watchdog forced a release |

## Verification
The main trials sweep the cycle at which a handshake arrives, from the first cycle of the wait past the watchdog limit. Each trial is run once with the data request and once with the interrupt request. The measured low time separates a handshake release from a watchdog release, and the trial at exactly the terminal cycle shows that a coincident handshake takes priority for the flag. Separate patterns cover a write with the enable bit clear, a request made while the data request is already high, a repeated write during a wait (which must not extend it), and reset applied mid-wait.

// File: rtl/wst_pkg.sv
package wst_pkg;
  // Reason a pending wait is released on the coming edge.
  typedef enum logic [1:0] {
    REL_NONE  = 2'd0,
    REL_DRQ   = 2'd1,
    REL_INTRQ = 2'd2,
    REL_WDOG  = 2'd3
  } rel_cause_e;
endpackage

// File: rtl/wst_release_arb.sv
module wst_release_arb
  import wst_pkg::*;
(
  input  logic       active,
  input  logic       drq,
  input  logic       intrq,
  input  logic       wdog_done,
  output logic       release_now,
  output rel_cause_e cause
);
  // Handshakes outrank the watchdog so a late answer is not flagged.
  always_comb begin
    cause = REL_NONE;
    if (active) begin
      if (drq)            cause = REL_DRQ;
      else if (intrq)     cause = REL_INTRQ;
      else if (wdog_done) cause = REL_WDOG;
    end
    release_now = (cause != REL_NONE);
  end
endmodule

// File: rtl/wst_watchdog.sv
module wst_watchdog #(
  parameter int WDOG_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic release_now,
  output logic done
);
  localparam int CW = (WDOG_CYCLES > 1) ? $clog2(WDOG_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WDOG_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (active && !release_now) cnt_q <= cnt_q + 1'b1;
    else                             cnt_q <= '0;
  end

  assign done = active && (cnt_q == LAST);

  AST_WDOG_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> cnt_q == '0);  // R6
  AST_WDOG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt_q <= LAST);  // R6
endmodule

// File: rtl/wst_req_ctl.sv
module wst_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wait_en,
  input  logic release_now,
  input  logic drq,
  input  logic intrq,
  output logic active
);
  logic active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              active_q <= 1'b0;
    else if (active_q)       active_q <= !release_now;
    else if (wr && wait_en)  active_q <= 1'b1;
  end

  assign active = active_q;

  AST_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && wr && wait_en) |=> active_q);  // R2
  AST_CLEAR_BIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && wr && !wait_en) |=> !active_q);  // R3
  AST_DRQ_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && drq) |=> !active_q);  // R4
  AST_INTRQ_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && intrq) |=> !active_q);  // R5
endmodule

// File: rtl/wait_stretch_ctl.sv
module wait_stretch_ctl
  import wst_pkg::*;
#(
  parameter int WDOG_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_wait_en,
  input  logic fdc_drq,
  input  logic fdc_intrq,
  output logic wait_n,
  output logic wdog_timeout
);
  logic       active;
  logic       wdog_done;
  logic       release_now;
  rel_cause_e cause;
  logic       tmo_q;

  wst_req_ctl u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (ctl_wr),
    .wait_en     (ctl_wait_en),
    .release_now (release_now),
    .drq         (fdc_drq),
    .intrq       (fdc_intrq),
    .active      (active)
  );

  wst_watchdog #(.WDOG_CYCLES(WDOG_CYCLES)) u_wdog (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (active),
    .release_now (release_now),
    .done        (wdog_done)
  );

  wst_release_arb u_arb (
    .active      (active),
    .drq         (fdc_drq),
    .intrq       (fdc_intrq),
    .wdog_done   (wdog_done),
    .release_now (release_now),
    .cause       (cause)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tmo_q <= 1'b0;
    else if (cause == REL_WDOG) tmo_q <= 1'b1;
  end

  assign wait_n       = !active;
  assign wdog_timeout = tmo_q;

  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |=> tmo_q);  // R7
  AST_WDOG_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == REL_WDOG) |=> (tmo_q && !active));  // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (wait_n && !wdog_timeout));  // R1
endmodule

// File: tb/wait_stretch_ctl_tb.sv
module wait_stretch_ctl_tb;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0, ctl_wait_en = 1'b0, fdc_drq = 1'b0, fdc_intrq = 1'b0;
  logic wait_n, wdog_timeout;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  wait_stretch_ctl #(.WDOG_CYCLES(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wait_en(ctl_wait_en),
    .fdc_drq(fdc_drq), .fdc_intrq(fdc_intrq),
    .wait_n(wait_n), .wdog_timeout(wdog_timeout)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ctl_wr = 0; ctl_wait_en = 0; fdc_drq = 0; fdc_intrq = 0;
    @(negedge clk);
    check("R1 wait_n in reset", wait_n, 1);
    check("R1 timeout in reset", wdog_timeout, 0);
    rst_n = 1'b1;
  endtask

  // Write at a negedge; the edge that follows captures it.
  task automatic post_write(logic en);
    ctl_wr = 1'b1; ctl_wait_en = en;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wait_en = 1'b0;
  endtask

  // Handshake raised after the m-th low sample.
  task automatic trial(int m, bit use_intrq);
    int low = 0;
    string tag;
    tag = use_intrq ? "R5" : "R4";
    do_reset();
    post_write(1'b1);
    for (int c = 1; c <= W + 3; c++) begin
      if (wait_n == 1'b0) low++;
      fdc_drq   = (c == m) && !use_intrq;
      fdc_intrq = (c == m) && use_intrq;
      @(negedge clk);
    end
    fdc_drq = 0; fdc_intrq = 0;
    check({tag, "/R6 low cycles"}, low, (m < W) ? m : W);
    check("R7 timeout flag", wdog_timeout, (m > W) ? 1 : 0);
    check("R6 released", wait_n, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int low;
    // Handshake sweep over both release sources
    for (int s = 0; s < 2; s++)
      for (int m = 1; m <= W + 2; m++) trial(m, s[0]);

    // R2: first low sample right after the capturing edge
    do_reset();
    post_write(1'b1);
    check("R2 wait_n after write", wait_n, 0);

    // R3: bit clear never stalls
    do_reset();
    post_write(1'b0);
    low = 0;
    for (int c = 0; c < W + 2; c++) begin
      if (wait_n == 1'b0) low++;
      @(negedge clk);
    end
    check("R3 low cycles with bit clear", low, 0);

    // R9: request while DRQ already high
    do_reset();
    fdc_drq = 1'b1;
    post_write(1'b1);
    check("R9 first cycle low", wait_n, 0);
    @(negedge clk);
    check("R9 released next cycle", wait_n, 1);
    fdc_drq = 1'b0;
    check("R9 no timeout", wdog_timeout, 0);

    // R8: repeated write does not extend
    do_reset();
    post_write(1'b1);
    low = 0;
    for (int c = 1; c <= W + 4; c++) begin
      if (wait_n == 1'b0) low++;
      ctl_wr = (c == 3); ctl_wait_en = (c == 3);
      @(negedge clk);
    end
    check("R8 low cycles with rewrite", low, W);
    check("R8 timeout still set", wdog_timeout, 1);

    // R7: sticky flag survives idle, then R1 reset clears it
    repeat (3) @(negedge clk);
    check("R7 flag sticky", wdog_timeout, 1);
    do_reset();
    check("R1 flag cleared", wdog_timeout, 0);

    // R1: asynchronous reset frees an active wait
    post_write(1'b1);
    @(negedge clk);
    check("R1 wait active before reset", wait_n, 0);
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async release", wait_n, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stays idle after reset", wait_n, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule